// File: doc/BRIEF.md
# Add/Subtract Execute Unit with Condition Flags

This block is the integer add/subtract stage of a 16/32-bit processor core. Each strobe presents one 16-bit instruction word together with an already fetched source value and destination value. The unit recognises three instruction families: register add/subtract with a sized source, quick add/subtract with a small constant carried in the instruction word, and address-register add/subtract that always works on 32 bits.

Sized forms operate on the low 8, 16 or 32 bits of the destination and keep its upper bits. They update the five condition flags. Address forms sign-extend a 16-bit source when asked to, and never touch the flags. An instruction word outside these families is reported as illegal. In that case the held result and flags do not change.

One cycle after the strobe, the registered result, flags, write-back size and illegal indication are valid, and a one-cycle done pulse marks them. Effective-address work and bus traffic happen elsewhere in the core.

Top module: `addsub_exec`

## Requirements
- R1: A word with bits 15:12 = 0x5 and bits 7:6 not equal to 11 is a quick form. Bit 8 = 0 adds and bit 8 = 1 subtracts. The second operand is the constant in bits 11:9, where a field of 0 means 8, and the source input is ignored.
- R2: A word with bits 15:12 = 0xD (add) or 0x9 (subtract) and bits 7:6 not equal to 11 computes destination plus or minus the source input.
- R3: For sized forms, bits 7:6 select the size: 00 is byte, 01 is word and 10 is long. Only the low 8, 16 or 32 result bits replace the destination, and the bits above them are kept. The write-back size output gives the same 2-bit code.
- R4: The flags output is ordered {X, N, Z, V, C} from bit 4 down to bit 0. C is the carry out of the active size for add and the borrow for subtract. X receives the same value as C.
- R5: N is the top bit of the sized result. Z is 1 exactly when every bit of the sized result is 0.
- R6: For add, V is 1 when both operands have the same top bit and the result's top bit differs from the destination's. For subtract, V is 1 when the operands' top bits differ and the result's top bit differs from the destination's.
- R7: A word with bits 15:12 = 0xD or 0x9 and bits 7:6 = 11 is an address form. If bit 8 = 0, the low 16 source bits are sign-extended; if bit 8 = 1, all 32 source bits are used. The add or subtract is done over 32 bits, the write-back size is 10 (long), and all five flags keep their values.
- R8: Any other word, including a quick form with bits 7:6 = 11, sets the illegal output to 1. The result, flags and write-back size outputs then keep their previous values.
- R9: The outputs change only on the clock edge that samples the start input high. The done output is 1 for exactly the cycle after each start and 0 otherwise.
- R10: While reset is high, the result, flags, write-back size, illegal and done outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Execute the presented instruction this cycle |
| opcode_i | input | 16 | Instruction word |
| src_i | input | LONG_W | Source operand |
| dst_i | input | LONG_W | Destination operand |
| result_o | output | LONG_W | Registered result value |
| flags_o | output | 5 | Condition flags {X,N,Z,V,C} |
| wb_size_o | output | 2 | Write-back size: 00 byte, 01 word, 10 long |
| illegal_o | output | 1 | Last instruction word was not recognised |
| done_o | output | 1 | One-cycle pulse: outputs updated |

## Verification
The bench builds the unit with the default LONG_W of 32. This gives the byte lane 8 bits and the word lane 16 bits, so the carry and overflow edges at bits 8, 16 and 32 can all be reached with ordinary directed operands such as 0x7F, 0xFFFF and 0xFFFFFFFF. At this width the bench's own 64-bit integer model can compute borrow and signed range directly. Directed corner cases (the quick constant 0 meaning 8, sign extension of a negative word, illegal words between valid ones) are followed by a random mix across all families.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } size_e;

  // Decoded view of one instruction word
  typedef struct packed {
    logic       legal;
    logic       is_sub;
    logic       is_addr;
    logic       use_imm;
    logic       addr_word;
    size_e      size;
    logic [3:0] imm;
  } dec_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0] opcode_i,
  output dec_t            dec_o
);

  logic [3:0] group;
  logic [1:0] szf;

  assign group = opcode_i[15:12];
  assign szf   = opcode_i[7:6];

  always_comb begin
    dec_o      = '0;
    dec_o.size = SZ_BYTE;
    if (group == 4'h5) begin
      if (szf != 2'b11) begin
        dec_o.legal   = 1'b1;
        dec_o.is_sub  = opcode_i[8];
        dec_o.use_imm = 1'b1;
        dec_o.size    = size_e'(szf);
        dec_o.imm     = (opcode_i[11:9] == 3'd0) ? 4'd8 : {1'b0, opcode_i[11:9]};
      end
    end else if (group == 4'hD || group == 4'h9) begin
      dec_o.legal  = 1'b1;
      dec_o.is_sub = (group == 4'h9);
      if (szf == 2'b11) begin
        dec_o.is_addr   = 1'b1;
        dec_o.addr_word = ~opcode_i[8];
        dec_o.size      = SZ_LONG;
      end else begin
        dec_o.size = size_e'(szf);
      end
    end
  end

endmodule

// File: rtl/addsub_lane.sv
module addsub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,   // destination
  input  logic [W-1:0] b_i,   // source or constant
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o,
  output logic         n_o,
  output logic         z_o
);

  logic [W:0] wide;

  assign wide  = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
  assign res_o = wide[W-1:0];
  assign c_o   = wide[W];
  assign n_o   = wide[W-1];
  assign z_o   = (wide[W-1:0] == '0);

  always_comb begin
    if (sub_i)
      v_o = (b_i[W-1] != a_i[W-1]) && (wide[W-1] != a_i[W-1]);
    else
      v_o = (b_i[W-1] == a_i[W-1]) && (wide[W-1] != a_i[W-1]);
  end

endmodule

// File: rtl/addsub_exec.sv
module addsub_exec
  import addsub_pkg::*;
#(
  parameter int LONG_W = 32,
  parameter int OP_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [LONG_W-1:0] src_i,
  input  logic [LONG_W-1:0] dst_i,
  output logic [LONG_W-1:0] result_o,
  output logic [4:0]        flags_o,
  output logic [1:0]        wb_size_o,
  output logic              illegal_o,
  output logic              done_o
);

  localparam int WORD_W = LONG_W / 2;
  localparam int BYTE_W = LONG_W / 4;
  localparam int NLANE  = 3;

  dec_t dec;

  addsub_decode #(.OP_W(OP_W)) u_dec (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  logic [LONG_W-1:0] operand_b;
  assign operand_b = dec.use_imm ? LONG_W'(dec.imm) : src_i;

  logic [LONG_W-1:0] lane_res [NLANE];
  logic [NLANE-1:0]  lane_c, lane_v, lane_n, lane_z;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = BYTE_W << i;
    localparam logic [LONG_W-1:0] KEEP = ~LONG_W'({LW{1'b1}});
    logic [LW-1:0] r_w;

    addsub_lane #(.W(LW)) u_lane (
      .a_i   (dst_i[LW-1:0]),
      .b_i   (operand_b[LW-1:0]),
      .sub_i (dec.is_sub),
      .res_o (r_w),
      .c_o   (lane_c[i]),
      .v_o   (lane_v[i]),
      .n_o   (lane_n[i]),
      .z_o   (lane_z[i])
    );

    assign lane_res[i] = (dst_i & KEEP) | LONG_W'(r_w);
  end

  // Address path: full width, optional sign extension of a word source
  logic [LONG_W-1:0] src_ext, addr_res;
  assign src_ext  = dec.addr_word ? {{(LONG_W-WORD_W){src_i[WORD_W-1]}}, src_i[WORD_W-1:0]} : src_i;
  assign addr_res = dec.is_sub ? (dst_i - src_ext) : (dst_i + src_ext);

  logic [LONG_W-1:0] sized_res;
  logic [4:0]        sized_flags;
  always_comb begin
    case (dec.size)
      SZ_BYTE: begin
        sized_res   = lane_res[0];
        sized_flags = {lane_c[0], lane_n[0], lane_z[0], lane_v[0], lane_c[0]};
      end
      SZ_WORD: begin
        sized_res   = lane_res[1];
        sized_flags = {lane_c[1], lane_n[1], lane_z[1], lane_v[1], lane_c[1]};
      end
      default: begin
        sized_res   = lane_res[2];
        sized_flags = {lane_c[2], lane_n[2], lane_z[2], lane_v[2], lane_c[2]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      flags_o   <= '0;
      wb_size_o <= '0;
      illegal_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        illegal_o <= ~dec.legal;
        if (dec.legal) begin
          wb_size_o <= dec.size;
          if (dec.is_addr) begin
            result_o <= addr_res;
          end else begin
            result_o <= sized_res;
            flags_o  <= sized_flags;
          end
        end
      end
    end
  end

  // ---------------- assertions ----------------
  a_r9_done_follows_start: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o);
  a_r9_no_start_quiet: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (!done_o && $stable(result_o) && $stable(flags_o)));
  a_r7_addr_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (start_i && dec.is_addr) |=> ($stable(flags_o) && wb_size_o == 2'b10));
  a_r8_illegal_holds: assert property (@(posedge clk) disable iff (rst)
    (start_i && !dec.legal) |=> (illegal_o && $stable(result_o) && $stable(flags_o) && $stable(wb_size_o)));
  a_r3_byte_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (start_i && dec.legal && !dec.is_addr && dec.size == SZ_BYTE)
      |=> (result_o[LONG_W-1:BYTE_W] == $past(dst_i[LONG_W-1:BYTE_W])));
  a_r4_extend_is_carry: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (flags_o[4] == flags_o[0]));
  a_r5_zero_matches_byte: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && wb_size_o == 2'b00 && $past(!dec.is_addr))
      |-> (flags_o[2] == (result_o[BYTE_W-1:0] == '0)));

endmodule

// File: tb/addsub_exec_test.sv
`timescale 1ns/1ps
module addsub_exec_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic [31:0] result_o;
  logic [4:0]  flags_o;
  logic [1:0]  wb_size_o;
  logic        illegal_o, done_o;

  always #2.5 clk = ~clk;

  addsub_exec uut (
    .clk(clk), .rst(rst), .start_i(start_i), .opcode_i(opcode_i),
    .src_i(src_i), .dst_i(dst_i), .result_o(result_o), .flags_o(flags_o),
    .wb_size_o(wb_size_o), .illegal_o(illegal_o), .done_o(done_o)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  fl;
    logic [1:0]  wb;
    logic        ill;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;

  // bench-held expected state
  logic [31:0] m_res = '0;
  logic [4:0]  m_fl  = '0;
  logic [1:0]  m_wb  = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Independent model built from the requirement text
  task automatic model(input logic [15:0] op, input logic [31:0] s, input logic [31:0] d,
                       output logic ill);
    int nib, sz, w;
    bit sub;
    longint m, ud, us, rr, rlow, sd, ss, sr, half, opnd;
    logic c, n, z, v;
    nib = int'(op[15:12]);
    sz  = int'(op[7:6]);
    ill = 1'b0;
    if (nib == 5 && sz != 3) begin
      opnd = (op[11:9] == 3'd0) ? 8 : longint'(op[11:9]);
      sub  = op[8];
    end else if ((nib == 9 || nib == 13) && sz != 3) begin
      opnd = longint'(s);
      sub  = (nib == 9);
    end else if (nib == 9 || nib == 13) begin
      opnd = op[8] ? longint'(s) : longint'(unsigned'(32'($signed(s[15:0]))));
      m_res = (nib == 13) ? d + 32'(opnd) : d - 32'(opnd);
      m_wb  = 2'b10;
      return;
    end else begin
      ill = 1'b1;
      return;
    end
    w    = 8 << sz;
    m    = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    ud   = longint'(d) & m;
    us   = opnd & m;
    rr   = sub ? ud - us : ud + us;
    c    = sub ? (ud < us) : (rr > m);
    rlow = rr & m;
    n    = ((rlow >> (w - 1)) & 1) != 0;
    z    = (rlow == 0);
    sd   = (ud >= half) ? ud - (half * 2) : ud;
    ss   = (us >= half) ? us - (half * 2) : us;
    sr   = sub ? sd - ss : sd + ss;
    v    = (sr > half - 1) || (sr < -half);
    m_res = (d & ~32'(m)) | 32'(rlow);
    m_fl  = {c, n, z, v, c};
    m_wb  = 2'(sz);
  endtask

  task automatic drive(input logic [15:0] op, input logic [31:0] s, input logic [31:0] d,
                       input string tag);
    item_t it;
    logic ill;
    model(op, s, d, ill);
    it.res = m_res; it.fl = m_fl; it.wb = m_wb; it.ill = ill; it.tag = tag;
    @(negedge clk);
    opcode_i = op; src_i = s; dst_i = d; start_i = 1'b1;
    q.push_back(it);
    @(negedge clk);
    start_i = 1'b0;
    opcode_i = $urandom(); src_i = $urandom(); dst_i = $urandom();
  endtask

  function automatic logic [15:0] quick(input bit sub, input int imm, input int sz);
    return {4'h5, 3'(imm), sub, 2'(sz), 6'b0};
  endfunction
  function automatic logic [15:0] gen(input bit sub, input int sz);
    return {sub ? 4'h9 : 4'hD, 3'd2, 1'b0, 2'(sz), 6'b0};
  endfunction
  function automatic logic [15:0] addr(input bit sub, input bit lng);
    return {sub ? 4'h9 : 4'hD, 3'd1, lng, 2'b11, 6'b0};
  endfunction

  // Monitor: pops expected items as results appear
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (done_o) begin
          if (q.size() == 0) begin
            check(1'b0, "R9", "unexpected done", 32'(done_o), 32'd0);
          end else begin
            it = q.pop_front();
            check(result_o == it.res, it.tag, "result", result_o, it.res);
            check(flags_o == it.fl, it.tag, "flags", 32'(flags_o), 32'(it.fl));
            check(wb_size_o == it.wb, it.tag, "wb_size", 32'(wb_size_o), 32'(it.wb));
            check(illegal_o == it.ill, it.tag, "illegal", 32'(illegal_o), 32'(it.ill));
          end
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "WATCHDOG", "timeout", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(result_o == 0 && flags_o == 0 && wb_size_o == 0 && !illegal_o && !done_o,
          "R10", "reset outputs", {result_o[26:0], flags_o}, 32'd0);
    rst = 1'b0;

    // R1: quick constant 0 means 8
    drive(quick(0, 0, 0), 32'hFFFF_FFFF, 32'hAABB_CC10, "R1_q0_is_8");
    drive(quick(1, 3, 1), 32'h0, 32'h1234_0002, "R1_subq_word");
    drive(quick(0, 7, 2), 32'h0, 32'hFFFF_FFFA, "R1_addq_long_carry");
    // R2
    drive(gen(0, 1), 32'h0000_8001, 32'h5555_8000, "R2_add_word");
    drive(gen(1, 2), 32'h0000_0005, 32'h0000_0003, "R2_sub_long_borrow");
    // R3: upper bits kept
    drive(gen(0, 0), 32'h0000_00FF, 32'hDEAD_BE01, "R3_byte_upper");
    drive(gen(1, 1), 32'hFFFF_0001, 32'hCAFE_0001, "R3_word_upper");
    // R4/R5
    drive(gen(0, 0), 32'h0000_0001, 32'h0000_00FF, "R4_byte_carry_zero");
    drive(gen(1, 0), 32'h0000_0001, 32'h0000_0000, "R5_byte_borrow_neg");
    // R6 overflow
    drive(gen(0, 0), 32'h1, 32'h7F, "R6_add_ovf");
    drive(gen(1, 0), 32'h1, 32'h80, "R6_sub_ovf");
    drive(gen(0, 2), 32'h8000_0000, 32'h8000_0000, "R6_add_long_neg_ovf");
    // R7 address forms, flags must hold from previous op
    drive(addr(0, 0), 32'h0000_8000, 32'h0001_0000, "R7_adda_word_sext");
    drive(addr(1, 1), 32'h0000_0010, 32'h0000_0008, "R7_suba_long");
    drive(addr(1, 0), 32'h1234_FFFF, 32'h0000_0000, "R7_suba_word_sext");
    // R8 illegal words
    drive(16'h4E71, 32'h1, 32'h2, "R8_illegal_other");
    drive(quick(0, 1, 3), 32'h1, 32'h2, "R8_illegal_quick_sz3");
    drive(16'h0000, 32'h1, 32'h2, "R8_illegal_zero");
    // R9 idle: no change without start
    repeat (6) @(negedge clk);
    #1;
    check(!done_o && result_o == m_res && flags_o == m_fl, "R9", "idle hold",
          result_o, m_res);
    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [15:0] op;
      case (k % 4)
        0: op = quick(1'($urandom()), $urandom_range(0, 7), $urandom_range(0, 2));
        1: op = gen(1'($urandom()), $urandom_range(0, 2));
        2: op = addr(1'($urandom()), 1'($urandom()));
        default: op = 16'($urandom());
      endcase
      drive(op, $urandom(), $urandom(), "R1_R2_R7_R8_mix");
    end
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9", "pending results", 32'(q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule